// File: doc/BRIEF.md
# Channel Activation Controller

This block runs the activation state of a single channel of a descriptor-driven copy / XOR / CRC engine. Software-style command pulses (start, stop, pause, restart) arrive on separate inputs. The controller keeps the channel status, which is idle, active or paused. It accepts a command only when the current status allows it, and it reports every command with a registered accept or reject response and a reason code.

The controller also holds the operation mode and the chain pointer for the channel. These two values can be rewritten only while the channel is not active. A start is accepted only when the stored chain pointer is non-null and aligned for the stored mode. A completion pulse from the datapath returns an active channel to idle. Descriptor fetch and the data movement itself are outside this block.

All outputs are registered. A command, configuration write or completion sampled on one rising edge is visible on the outputs right after that edge.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Status encoding is 2'b00 idle, 2'b01 active, 2'b10 paused; 2'b11 never appears. Reset (synchronous, active high) gives idle, no response, cfg_busy low, mode 2'b00 and pointer 0.
- R2: A start from idle with a valid pointer moves status to active after the edge, with resp_ok high and resp_code 2'b00.
- R3: A start from paused with a valid pointer, or a restart from paused, moves status to active and is accepted. Restart in any other status is rejected.
- R4: A pause is accepted only while active and moves status to paused.
- R5: Stop while active moves status to idle and is accepted. Stop while idle is accepted and changes nothing. Stop while paused is rejected.
- R6: Any other command and status pairing is rejected with resp_code 2'b01, and status is unchanged.
- R7: A start in mode 2'b01 (XOR) needs pointer bits [5:0] all zero. In mode 2'b00 (copy) or 2'b10 (CRC) it needs bits [4:0] all zero. A violation is rejected with resp_code 2'b10 and status is unchanged.
- R8: A start with a pointer of zero, or with mode 2'b11, is rejected with resp_code 2'b10.
- R9: A configuration write while status is active is dropped: mode and pointer keep their values, and cfg_busy is high for one cycle. In idle or paused the write is applied after the edge and cfg_busy stays low.
- R10: When several command pulses coincide, exactly one is evaluated. The order is stop, then pause, then restart, then start.
- R11: A completion pulse while active moves status to idle, and any command in that same cycle is rejected with resp_code 2'b01. A completion in idle or paused has no effect.
- R12: resp_valid is high for exactly the one cycle after a command cycle. resp_ok is high exactly when resp_valid is high and resp_code is 2'b00. With no command, resp_code reads 2'b00.
- R13: Legality and pointer checks use the status, mode and pointer held before the edge. A configuration write in the same cycle as a start therefore does not affect that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_pause | input | 1 | Pause command pulse |
| cmd_restart | input | 1 | Restart command pulse |
| xfer_done | input | 1 | Completion pulse from the datapath |
| cfg_we | input | 1 | Write strobe for mode and pointer |
| cfg_mode | input | 2 | Mode to write: 00 copy, 01 XOR, 10 CRC, 11 reserved |
| cfg_ptr | input | PTR_W | Chain pointer to write |
| status | output | 2 | Channel status |
| resp_valid | output | 1 | Response to the previous cycle's command |
| resp_ok | output | 1 | Command accepted |
| resp_code | output | 2 | 00 accepted, 01 wrong status, 10 bad pointer or mode |
| cfg_busy | output | 1 | Previous configuration write was dropped |
| mode_q | output | 2 | Stored mode |
| ptr_q | output | PTR_W | Stored chain pointer |

## Verification
Single commands are applied in every status, so that each legal transition can be told apart from a rejection on status grounds. Starts are tried with pointers that are 32-byte aligned but not 64-byte aligned, in XOR and in the 32-byte modes, together with a null pointer and the reserved mode. This separates the two alignment rules and the pointer rejections from status rejections. Coinciding command pulses in each status show which command wins. Completion pulses that coincide with commands, and completions outside the active status, show the precedence of completion and that it is otherwise ignored. Configuration writes in active and in paused status show when the stored values may change.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_PAUSED = 2'b10
  } chan_st_t;

  typedef enum logic [1:0] {
    OP_COPY = 2'b00,
    OP_XOR  = 2'b01,
    OP_CRC  = 2'b10,
    OP_RSVD = 2'b11
  } op_mode_t;

  typedef enum logic [1:0] {
    RC_OK    = 2'b00,
    RC_STATE = 2'b01,
    RC_PTR   = 2'b10
  } resp_code_t;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_RESTART = 3'd2,
    CMD_PAUSE   = 3'd3,
    CMD_STOP    = 3'd4
  } cmd_t;
endpackage

// File: rtl/dcc_cmd_arb.sv
module dcc_cmd_arb
  import dcc_pkg::*;
(
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic cmd_pause,
  input  logic cmd_restart,
  output cmd_t cmd_sel
);
  // Fixed priority: stop, pause, restart, start (R10)
  always_comb begin
    if (cmd_stop)         cmd_sel = CMD_STOP;
    else if (cmd_pause)   cmd_sel = CMD_PAUSE;
    else if (cmd_restart) cmd_sel = CMD_RESTART;
    else if (cmd_start)   cmd_sel = CMD_START;
    else                  cmd_sel = CMD_NONE;
  end
endmodule

// File: rtl/dcc_ptr_check.sv
module dcc_ptr_check
  import dcc_pkg::*;
#(
  parameter int PTR_W        = 32,
  parameter int WIDE_ALIGN   = 6,
  parameter int NARROW_ALIGN = 5
) (
  input  logic [1:0]       mode,
  input  logic [PTR_W-1:0] ptr,
  output logic             ptr_ok
);
  localparam logic [PTR_W-1:0] WIDE_MASK   = PTR_W'((64'd1 << WIDE_ALIGN) - 64'd1);
  localparam logic [PTR_W-1:0] NARROW_MASK = PTR_W'((64'd1 << NARROW_ALIGN) - 64'd1);

  logic             low_clear;
  logic             mode_known;
  logic             non_null;

  generate
    if (WIDE_ALIGN == NARROW_ALIGN) begin : g_one_rule
      assign low_clear = ((ptr & NARROW_MASK) == '0);
    end else begin : g_two_rules
      logic [PTR_W-1:0] sel_mask;
      always_comb begin
        if (op_mode_t'(mode) == OP_XOR) sel_mask = WIDE_MASK;
        else                            sel_mask = NARROW_MASK;
      end
      assign low_clear = ((ptr & sel_mask) == '0);
    end
  endgenerate

  assign mode_known = (op_mode_t'(mode) != OP_RSVD);
  assign non_null   = (ptr != '0);
  assign ptr_ok     = low_clear && mode_known && non_null;
endmodule

// File: rtl/dcc_cfg_regs.sv
module dcc_cfg_regs #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       mode_in,
  input  logic [PTR_W-1:0] ptr_in,
  input  logic             chan_active,
  output logic [1:0]       mode_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic             busy_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= we && chan_active;
      if (we && !chan_active) begin
        mode_q <= mode_in;
        ptr_q  <= ptr_in;
      end
    end
  end
endmodule

// File: rtl/dcc_state_fsm.sv
module dcc_state_fsm
  import dcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmd_t       cmd_sel,
  input  logic       done,
  input  logic       ptr_ok,
  output chan_st_t   state_q,
  output logic       resp_valid_q,
  output logic       resp_ok_q,
  output resp_code_t resp_code_q
);
  chan_st_t   nxt;
  resp_code_t code;

  always_comb begin
    nxt  = state_q;
    code = RC_OK;
    if (state_q == ST_ACTIVE && done) begin
      nxt  = ST_IDLE;
      code = RC_STATE;
    end else begin
      unique case (cmd_sel)
        CMD_STOP: begin
          if (state_q == ST_ACTIVE)    nxt  = ST_IDLE;
          else if (state_q != ST_IDLE) code = RC_STATE;
        end
        CMD_PAUSE: begin
          if (state_q == ST_ACTIVE) nxt  = ST_PAUSED;
          else                      code = RC_STATE;
        end
        CMD_RESTART: begin
          if (state_q == ST_PAUSED) nxt  = ST_ACTIVE;
          else                      code = RC_STATE;
        end
        CMD_START: begin
          if (state_q == ST_ACTIVE) code = RC_STATE;
          else if (!ptr_ok)         code = RC_PTR;
          else                      nxt  = ST_ACTIVE;
        end
        default: code = RC_OK;
      endcase
    end
    if (cmd_sel == CMD_NONE) code = RC_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      resp_valid_q <= 1'b0;
      resp_ok_q    <= 1'b0;
      resp_code_q  <= RC_OK;
    end else begin
      state_q      <= nxt;
      resp_valid_q <= (cmd_sel != CMD_NONE);
      resp_ok_q    <= (cmd_sel != CMD_NONE) && (code == RC_OK);
      resp_code_q  <= code;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dcc_pkg::*;
#(
  parameter int PTR_W        = 32,
  parameter int WIDE_ALIGN   = 6,
  parameter int NARROW_ALIGN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_pause,
  input  logic             cmd_restart,
  input  logic             xfer_done,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [PTR_W-1:0] cfg_ptr,
  output logic [1:0]       status,
  output logic             resp_valid,
  output logic             resp_ok,
  output logic [1:0]       resp_code,
  output logic             cfg_busy,
  output logic [1:0]       mode_q,
  output logic [PTR_W-1:0] ptr_q
);
  cmd_t       cmd_sel;
  chan_st_t   st;
  resp_code_t code_q;
  logic       ptr_ok;

  dcc_cmd_arb u_arb (
    .cmd_start   (cmd_start),
    .cmd_stop    (cmd_stop),
    .cmd_pause   (cmd_pause),
    .cmd_restart (cmd_restart),
    .cmd_sel     (cmd_sel)
  );

  dcc_cfg_regs #(.PTR_W(PTR_W)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .we          (cfg_we),
    .mode_in     (cfg_mode),
    .ptr_in      (cfg_ptr),
    .chan_active (st == ST_ACTIVE),
    .mode_q      (mode_q),
    .ptr_q       (ptr_q),
    .busy_q      (cfg_busy)
  );

  dcc_ptr_check #(
    .PTR_W        (PTR_W),
    .WIDE_ALIGN   (WIDE_ALIGN),
    .NARROW_ALIGN (NARROW_ALIGN)
  ) u_chk_ptr (
    .mode   (mode_q),
    .ptr    (ptr_q),
    .ptr_ok (ptr_ok)
  );

  dcc_state_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cmd_sel      (cmd_sel),
    .done         (xfer_done),
    .ptr_ok       (ptr_ok),
    .state_q      (st),
    .resp_valid_q (resp_valid),
    .resp_ok_q    (resp_ok),
    .resp_code_q  (code_q)
  );

  assign status    = st;
  assign resp_code = code_q;
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             cmd_pause,
  input logic             cmd_restart,
  input logic             xfer_done,
  input logic [1:0]       status,
  input logic             resp_valid,
  input logic             resp_ok,
  input logic [1:0]       resp_code,
  input logic             cfg_busy,
  input logic [1:0]       mode_q,
  input logic [PTR_W-1:0] ptr_q
);
  p_status_legal_r1: assert property (@(posedge clk) disable iff (rst)
    status != 2'b11);

  p_pause_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b10 && $past(status) == 2'b01) |-> $past(cmd_pause));

  p_active_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01 && $past(status) != 2'b01) |-> ($past(cmd_start) || $past(cmd_restart)));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01 && xfer_done) |=> (status == 2'b00));

  p_busy_source_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |-> ($past(status) == 2'b01));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01) |=> ($stable(mode_q) && $stable(ptr_q)));

  p_resp_after_cmd_r12: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(cmd_start || cmd_stop || cmd_pause || cmd_restart));

  p_ok_consistent_r12: assert property (@(posedge clk) disable iff (rst)
    resp_ok |-> (resp_valid && resp_code == 2'b00));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.PTR_W(PTR_W)) u_bound_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_start   (cmd_start),
  .cmd_stop    (cmd_stop),
  .cmd_pause   (cmd_pause),
  .cmd_restart (cmd_restart),
  .xfer_done   (xfer_done),
  .status      (status),
  .resp_valid  (resp_valid),
  .resp_ok     (resp_ok),
  .resp_code   (resp_code),
  .cfg_busy    (cfg_busy),
  .mode_q      (mode_q),
  .ptr_q       (ptr_q)
);

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_start = 0, s_stop = 0, s_pause = 0, s_restart = 0, s_done = 0, s_we = 0;
  logic [1:0]  s_mode = 0;
  logic [31:0] s_ptr = 0;
  logic [1:0]  status, resp_code, mode_q;
  logic        resp_valid, resp_ok, cfg_busy;
  logic [31:0] ptr_q;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dma_chan_ctrl uut (
    .clk(clk), .rst(rst), .cmd_start(s_start), .cmd_stop(s_stop),
    .cmd_pause(s_pause), .cmd_restart(s_restart), .xfer_done(s_done),
    .cfg_we(s_we), .cfg_mode(s_mode), .cfg_ptr(s_ptr), .status(status),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_code(resp_code),
    .cfg_busy(cfg_busy), .mode_q(mode_q), .ptr_q(ptr_q)
  );

  // Behavioural reference model
  int m_st = 0, m_mode = 0, m_code = 0;
  longint m_ptr = 0;
  bit m_rv = 0, m_ok = 0, m_busy = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_mode = 0; m_ptr = 0; m_rv = 0; m_ok = 0; m_code = 0; m_busy = 0;
    end else begin
      int c, ns, code;
      bit pok;
      c = s_stop ? 4 : s_pause ? 3 : s_restart ? 2 : s_start ? 1 : 0;
      pok = (m_ptr != 0) && (m_mode != 3) &&
            ((m_mode == 1) ? (m_ptr % 64 == 0) : (m_ptr % 32 == 0));
      ns = m_st; code = 0;
      if (m_st == 1 && s_done) begin ns = 0; code = 1; end
      else if (c == 4) begin if (m_st == 1) ns = 0; else if (m_st == 2) code = 1; end
      else if (c == 3) begin if (m_st == 1) ns = 2; else code = 1; end
      else if (c == 2) begin if (m_st == 2) ns = 1; else code = 1; end
      else if (c == 1) begin
        if (m_st == 1) code = 1; else if (!pok) code = 2; else ns = 1;
      end
      if (c == 0) code = 0;
      m_rv = (c != 0); m_ok = (c != 0) && (code == 0); m_code = code;
      m_busy = s_we && (m_st == 1);
      if (s_we && m_st != 1) begin m_mode = s_mode; m_ptr = s_ptr; end
      m_st = ns;
    end
  end

  always @(posedge clk) begin
    #5;
    if (!rst) begin
      tests++;
      if (status != m_st[1:0] || resp_valid != m_rv || resp_ok != m_ok ||
          resp_code != m_code[1:0] || cfg_busy != m_busy ||
          mode_q != m_mode[1:0] || ptr_q != m_ptr[31:0]) begin
        fails++;
        $display("FAIL %s: got st=%0d rv=%0d ok=%0d code=%0d busy=%0d mode=%0d ptr=%h exp st=%0d rv=%0d ok=%0d code=%0d busy=%0d mode=%0d ptr=%h",
          cur_req, status, resp_valid, resp_ok, resp_code, cfg_busy, mode_q, ptr_q,
          m_st, m_rv, m_ok, m_code, m_busy, m_mode, m_ptr[31:0]);
      end
    end
  end

  task automatic drive(input bit st, sp, ps, rs, dn, we, input logic [1:0] md, input logic [31:0] pt);
    @(negedge clk);
    s_start = st; s_stop = sp; s_pause = ps; s_restart = rs; s_done = dn;
    s_we = we; s_mode = md; s_ptr = pt;
  endtask

  task automatic idle(); drive(0,0,0,0,0,0,2'b00,32'h0); endtask

  // Direct check of the outputs right after the previous command's edge
  task automatic expect_out(input string req, input logic [1:0] st, input bit ok, input logic [1:0] code);
    tests++;
    if (status != st || resp_ok != ok || resp_code != code) begin
      fails++;
      $display("FAIL %s: got st=%0d ok=%0d code=%0d exp st=%0d ok=%0d code=%0d",
               req, status, resp_ok, resp_code, st, ok, code);
    end
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: got running exp finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    tests++;
    if (status != 2'b00 || resp_valid || cfg_busy || mode_q != 0 || ptr_q != 0) begin
      fails++;
      $display("FAIL R1: got st=%0d rv=%0d busy=%0d exp reset values", status, resp_valid, cfg_busy);
    end
    cur_req = "R8";
    drive(1,0,0,0,0,0,0,0); idle(); expect_out("R8", 2'b00, 0, 2'b10);
    cur_req = "R7";
    drive(0,0,0,0,0,1,2'b01,32'h1000_0020); idle();
    drive(1,0,0,0,0,0,0,0); idle(); expect_out("R7", 2'b00, 0, 2'b10);
    cur_req = "R13";
    drive(1,0,0,0,0,1,2'b01,32'h1000_0040); idle(); expect_out("R13", 2'b00, 0, 2'b10);
    cur_req = "R2";
    drive(1,0,0,0,0,0,0,0); idle(); expect_out("R2", 2'b01, 1, 2'b00);
    cur_req = "R12";
    idle(); tests++;
    if (resp_valid || resp_code != 0) begin
      fails++; $display("FAIL R12: got rv=%0d code=%0d exp 0 0", resp_valid, resp_code);
    end
    cur_req = "R9";
    drive(0,0,0,0,0,1,2'b00,32'h0000_0020); idle(); tests++;
    if (!cfg_busy || ptr_q != 32'h1000_0040 || mode_q != 2'b01) begin
      fails++; $display("FAIL R9: got busy=%0d ptr=%h exp 1 10000040", cfg_busy, ptr_q);
    end
    cur_req = "R6";
    drive(1,0,0,0,0,0,0,0); idle(); expect_out("R6", 2'b01, 0, 2'b01);
    drive(0,0,0,1,0,0,0,0); idle(); expect_out("R6", 2'b01, 0, 2'b01);
    cur_req = "R4";
    drive(0,0,1,0,0,0,0,0); idle(); expect_out("R4", 2'b10, 1, 2'b00);
    drive(0,0,1,0,0,0,0,0); idle(); expect_out("R4", 2'b10, 0, 2'b01);
    cur_req = "R11";
    drive(0,0,0,0,1,0,0,0); idle(); expect_out("R11", 2'b10, 0, 2'b00);
    cur_req = "R9";
    drive(0,0,0,0,0,1,2'b00,32'h0000_0020); idle(); tests++;
    if (cfg_busy || ptr_q != 32'h20 || mode_q != 2'b00) begin
      fails++; $display("FAIL R9: got busy=%0d ptr=%h exp 0 00000020", cfg_busy, ptr_q);
    end
    cur_req = "R3";
    drive(1,0,0,0,0,0,0,0); idle(); expect_out("R3", 2'b01, 1, 2'b00);
    drive(0,0,1,0,0,0,0,0); idle();
    drive(0,0,0,1,0,0,0,0); idle(); expect_out("R3", 2'b01, 1, 2'b00);
    cur_req = "R5";
    drive(0,1,0,0,0,0,0,0); idle(); expect_out("R5", 2'b00, 1, 2'b00);
    drive(0,1,0,0,0,0,0,0); idle(); expect_out("R5", 2'b00, 1, 2'b00);
    cur_req = "R6";
    drive(0,0,1,0,0,0,0,0); idle(); expect_out("R6", 2'b00, 0, 2'b01);
    drive(0,0,0,1,0,0,0,0); idle(); expect_out("R3", 2'b00, 0, 2'b01);
    cur_req = "R8";
    drive(0,0,0,0,0,1,2'b11,32'h40); idle();
    drive(1,0,0,0,0,0,0,0); idle(); expect_out("R8", 2'b00, 0, 2'b10);
    cur_req = "R7";
    drive(0,0,0,0,0,1,2'b10,32'h60); idle();
    drive(1,0,0,0,0,0,0,0); idle(); expect_out("R7", 2'b01, 1, 2'b00);
    cur_req = "R11";
    drive(0,0,1,0,1,0,0,0); idle(); expect_out("R11", 2'b00, 0, 2'b01);
    drive(1,0,0,0,1,0,0,0); idle(); expect_out("R11", 2'b01, 1, 2'b00);
    drive(0,0,0,0,1,0,0,0); idle(); expect_out("R11", 2'b00, 0, 2'b00);
    cur_req = "R10";
    drive(1,0,0,0,0,0,0,0); idle();
    drive(0,1,1,0,0,0,0,0); idle(); expect_out("R10", 2'b00, 1, 2'b00);
    drive(1,0,1,0,0,0,0,0); idle(); expect_out("R10", 2'b00, 0, 2'b01);
    drive(1,0,0,0,0,0,0,0); idle();
    drive(0,0,1,0,0,0,0,0); idle();
    drive(1,0,0,1,0,0,0,0); idle(); expect_out("R10", 2'b01, 1, 2'b00);
    cur_req = "R5";
    drive(0,0,1,0,0,0,0,0); idle();
    drive(0,1,0,0,0,0,0,0); idle(); expect_out("R5", 2'b10, 0, 2'b01);
    idle(); idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule